// File: doc/BRIEF.md
# Masked Vector Execution Unit

This unit runs one integer operation across the elements of two source vector registers, one element per cycle, and writes results through a single destination write port. A per-element mask register decides which elements are written. Elements whose mask bit is clear are left untouched in the destination. Elements at or beyond the active vector length are never written.

Two schedules are selectable per command. In the stepping schedule every element up to the vector length gets a cycle, and the mask only gates the write strobe. In the skipping schedule the mask is scanned, and only enabled elements get a cycle. This makes the run time follow the number of enabled elements rather than the vector length.

Two commands act on the mask itself. One turns every mask bit on. The other fills the mask with the result of a signed greater-than comparison between each element of the first source and a scalar. A later masked operation can then act only where that comparison held.

Top module: `masked_vec_unit`

## Requirements
- R1: After reset `busy`, `done` and `wr_en` are 0, and every mask bit is 1, so the first masked command writes every element below the vector length.
- R2: `start` is accepted only in a cycle where `busy` is 0. A `start` raised while a command runs is ignored. One cycle after `done`, `busy` is 0.
- R3: With `dense_mode`=0, an arithmetic command takes max(VL,1) cycles. Cycle k presents element k on `wr_idx`, and `wr_en` equals mask bit k.
- R4: With `dense_mode`=1, an arithmetic command takes max(P,1) cycles, where P is the number of set mask bits below VL. Enabled elements are written in ascending index order, one per cycle, with `wr_en`=1. When P=0 the single cycle has `wr_en`=0.
- R5: The `op` code selects the element result on `wr_data`, with wrap-around on overflow: 0 gives a+b, 1 gives a-b, 2 gives a AND b, 3 gives a OR b.
- R6: `vl` ranges from 0 to NELEM. No write is ever issued for an element index at or above the latched `vl`.
- R7: Op code 4 sets every mask bit to 1. It takes one cycle and issues no write.
- R8: Op code 5 sets mask bit i to 1 when element i of `src_a`, taken as signed, is greater than the signed `scalar` and i < VL. Every other mask bit is cleared. It takes one cycle and issues no write.
- R9: `done` is high for exactly one cycle per command: the last cycle in which `busy` is 1.
- R10: Arithmetic commands leave the mask unchanged. Op codes 6 and 7 take one cycle, issue no write and leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a command (taken when idle) |
| dense_mode | input | 1 | 0: stepping schedule, 1: skipping schedule |
| op | input | 3 | Command code |
| vl | input | IW | Vector length, 0..NELEM |
| src_a | input | NELEM*EW | First source vector, element i at bits i*EW |
| src_b | input | NELEM*EW | Second source vector |
| scalar | input | EW | Scalar operand for the compare |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last cycle of the command |
| wr_en | output | 1 | Destination element write strobe |
| wr_idx | output | IW | Destination element index |
| wr_data | output | EW | Destination element value |

## Verification
The bench uses the default build of eight 16-bit elements. At this size every one of the 256 mask patterns can be produced through the compare command and then replayed under the skipping schedule, with vector lengths from 0 to 8. That covers the empty mask, the full mask, and enabled bits that sit beyond the vector length. The 16-bit width keeps the sign boundary of the compare and the wrap-around of add and subtract easy to hit with chosen values.

// File: rtl/vmask_pkg.sv
// Shared command codes for the masked vector unit.
// Assumes a 3-bit command field; codes 6 and 7 are reserved no-ops.
package vmask_pkg;
    typedef enum logic [2:0] {
        VOP_ADD  = 3'd0,
        VOP_SUB  = 3'd1,
        VOP_AND  = 3'd2,
        VOP_OR   = 3'd3,
        VOP_MSET = 3'd4,
        VOP_MGT  = 3'd5,
        VOP_RSV6 = 3'd6,
        VOP_RSV7 = 3'd7
    } vop_e;
endpackage

// File: rtl/vmask_alu.sv
// Element operation: combines one element of each source under the command code.
// Assumes the caller only uses the result for arithmetic codes (0..3).
module vmask_alu
    import vmask_pkg::*;
#(
    parameter int EW = 16
) (
    input  vop_e          op,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    output logic [EW-1:0] y
);
    // Select the element result; wrap-around arithmetic.
    always_comb begin
        case (op)
            VOP_ADD: y = a + b;
            VOP_SUB: y = a - b;
            VOP_AND: y = a & b;
            VOP_OR:  y = a | b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/vmask_scan.sv
// Finds the lowest enabled element at or above a start index and below the
// vector length. Also reports whether a further enabled element follows.
// Assumes vl <= NELEM.
module vmask_scan #(
    parameter int NELEM = 8,
    parameter int IW    = 4
) (
    input  logic [NELEM-1:0] mask,
    input  logic [IW-1:0]    vl,
    input  logic [IW-1:0]    from,
    output logic             found,
    output logic [IW-1:0]    pos,
    output logic             more
);
    // Priority search from low to high index, flagging a second hit.
    always_comb begin
        found = 1'b0;
        more  = 1'b0;
        pos   = '0;
        for (int i = 0; i < NELEM; i++) begin
            if (mask[i] && (IW'(i) < vl) && (IW'(i) >= from)) begin
                if (found) begin
                    more = 1'b1;
                end else begin
                    found = 1'b1;
                    pos   = IW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/vmask_cmp.sv
// Builds a new mask from a signed element-versus-scalar greater-than test.
// Lanes at or above the vector length yield 0.
module vmask_cmp #(
    parameter int NELEM = 8,
    parameter int EW    = 16,
    parameter int IW    = 4
) (
    input  logic [NELEM*EW-1:0] vec,
    input  logic [EW-1:0]       scalar,
    input  logic [IW-1:0]       vl,
    output logic [NELEM-1:0]    mask
);
    for (genvar g = 0; g < NELEM; g++) begin : g_lane
        // One comparator per lane, gated by the vector length.
        assign mask[g] = (IW'(g) < vl) &&
                         ($signed(vec[g*EW +: EW]) > $signed(scalar));
    end
endmodule

// File: rtl/masked_vec_unit.sv
// Masked vector execution unit: applies an element operation under a mask,
// using either a stepping schedule (all elements, gated writes) or a
// skipping schedule (only enabled elements). Mask commands set all bits or
// load a compare result. Assumes vl <= NELEM; operands are latched at start.
module masked_vec_unit
    import vmask_pkg::*;
#(
    parameter int NELEM = 8,
    parameter int EW    = 16,
    localparam int IW   = $clog2(NELEM + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                dense_mode,
    input  logic [2:0]          op,
    input  logic [IW-1:0]       vl,
    input  logic [NELEM*EW-1:0] src_a,
    input  logic [NELEM*EW-1:0] src_b,
    input  logic [EW-1:0]       scalar,
    output logic                busy,
    output logic                done,
    output logic                wr_en,
    output logic [IW-1:0]       wr_idx,
    output logic [EW-1:0]       wr_data
);
    localparam int VW = NELEM * EW;

    logic              busy_q;
    logic              dense_q;
    vop_e              op_q;
    logic [IW-1:0]     vl_q;
    logic [VW-1:0]     a_q;
    logic [VW-1:0]     b_q;
    logic [EW-1:0]     s_q;
    logic [IW-1:0]     cur_q;
    logic [NELEM-1:0]  mask_q;

    logic              arith;
    logic              scan_found;
    logic              scan_more;
    logic [IW-1:0]     scan_pos;
    logic [IW-1:0]     idx;
    logic              we;
    logic              last;
    logic [IW-1:0]     cur_nxt;
    logic [EW-1:0]     a_el;
    logic [EW-1:0]     b_el;
    logic [EW-1:0]     alu_y;
    logic [NELEM-1:0]  cmp_mask;

    assign arith = (op_q[2] == 1'b0);

    vmask_scan #(.NELEM(NELEM), .IW(IW)) u_scan (
        .mask  (mask_q),
        .vl    (vl_q),
        .from  (cur_q),
        .found (scan_found),
        .pos   (scan_pos),
        .more  (scan_more)
    );

    vmask_cmp #(.NELEM(NELEM), .EW(EW), .IW(IW)) u_cmp (
        .vec    (a_q),
        .scalar (s_q),
        .vl     (vl_q),
        .mask   (cmp_mask)
    );

    // Pick the element of this cycle and decide write strobe and end of run.
    always_comb begin
        idx     = dense_q ? scan_pos : cur_q;
        cur_nxt = idx + IW'(1);
        if (arith) begin
            if (dense_q) begin
                we   = scan_found;
                last = !scan_more;
            end else begin
                we   = (idx < vl_q) && |(mask_q & (NELEM'(1) << idx));
                last = ({1'b0, cur_q} + (IW+1)'(1)) >= {1'b0, vl_q};
            end
        end else begin
            we   = 1'b0;
            last = 1'b1;
        end
    end

    assign a_el = EW'(a_q >> (idx * EW));
    assign b_el = EW'(b_q >> (idx * EW));

    vmask_alu #(.EW(EW)) u_alu (
        .op (op_q),
        .a  (a_el),
        .b  (b_el),
        .y  (alu_y)
    );

    // Command sequencing, operand capture and mask updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            dense_q <= 1'b0;
            op_q    <= VOP_ADD;
            vl_q    <= '0;
            a_q     <= '0;
            b_q     <= '0;
            s_q     <= '0;
            cur_q   <= '0;
            mask_q  <= '1;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                dense_q <= dense_mode;
                op_q    <= vop_e'(op);
                vl_q    <= vl;
                a_q     <= src_a;
                b_q     <= src_b;
                s_q     <= scalar;
                cur_q   <= '0;
            end
        end else if (last) begin
            busy_q <= 1'b0;
            if (op_q == VOP_MSET) mask_q <= '1;
            if (op_q == VOP_MGT)  mask_q <= cmp_mask;
        end else begin
            cur_q <= cur_nxt;
        end
    end

    assign busy    = busy_q;
    assign done    = busy_q && last;
    assign wr_en   = busy_q && we;
    assign wr_idx  = idx;
    assign wr_data = alu_y;
endmodule

// File: rtl/vmask_chk.sv
// Protocol and schedule checks for masked_vec_unit, attached by bind.
module vmask_chk #(
    parameter int NELEM = 8,
    parameter int IW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             wr_en,
    input logic [IW-1:0]    wr_idx,
    input logic [IW-1:0]    vl_q,
    input logic             dense_q,
    input logic             arith,
    input logic [NELEM-1:0] mask_q
);
    // R9
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R9
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R2
    run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R6
    write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < vl_q));
    // R3
    step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dense_q && arith && !done) |=> (wr_idx == $past(wr_idx) + IW'(1)));
    // R4
    skip_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dense_q && arith && !done) |=> (wr_idx > $past(wr_idx)));
    // R4
    skip_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dense_q && arith && !done) |-> wr_en);
    // R10
    mask_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && arith) |=> $stable(mask_q));
endmodule

bind masked_vec_unit vmask_chk #(.NELEM(NELEM), .IW(IW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .vl_q    (vl_q),
    .dense_q (dense_q),
    .arith   (arith),
    .mask_q  (mask_q)
);

// File: tb/test_masked_vec_unit.sv
module test_masked_vec_unit;
    localparam int NE = 8;
    localparam int EW = 16;
    localparam int IW = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             dense_mode = 1'b0;
    logic [2:0]       op = 3'd0;
    logic [IW-1:0]    vl = '0;
    logic [NE*EW-1:0] src_a = '0;
    logic [NE*EW-1:0] src_b = '0;
    logic [EW-1:0]    scalar = '0;
    logic             busy, done, wr_en;
    logic [IW-1:0]    wr_idx;
    logic [EW-1:0]    wr_data;

    int checks = 0;
    int fails  = 0;
    int ea [NE];
    int eb [NE];
    int es = 0;
    bit ref_mask [NE];

    bit    q_we [$];
    int    q_idx [$];
    int    q_data [$];
    string q_tag [$];

    always #10 clk = ~clk;

    masked_vec_unit #(.NELEM(NE), .EW(EW)) i_masked_vec_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .dense_mode(dense_mode),
        .op(op), .vl(vl), .src_a(src_a), .src_b(src_b), .scalar(scalar),
        .busy(busy), .done(done), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int elem_res(input int code, input int a, input int b);
        case (code)
            0: return (a + b) & 32'hFFFF;
            1: return (a - b) & 32'hFFFF;
            2: return a & b;
            default: return a | b;
        endcase
    endfunction

    function automatic int to_signed(input int v);
        return (v >= 32768) ? v - 65536 : v;
    endfunction

    // Builds the per-cycle expectation and runs one command.
    task automatic run_cmd(input int code, input bit dense, input int vlen,
                           input bit poke, input string force_tag);
        int n;
        q_we.delete(); q_idx.delete(); q_data.delete(); q_tag.delete();
        if (code < 4) begin
            if (!dense) begin
                n = (vlen > 0) ? vlen : 1;
                for (int k = 0; k < n; k++) begin
                    q_we.push_back(k < vlen && ref_mask[k]);
                    q_idx.push_back(k);
                    q_data.push_back(elem_res(code, ea[k], eb[k]));
                    q_tag.push_back("R3");
                end
            end else begin
                for (int k = 0; k < vlen; k++) begin
                    if (ref_mask[k]) begin
                        q_we.push_back(1'b1);
                        q_idx.push_back(k);
                        q_data.push_back(elem_res(code, ea[k], eb[k]));
                        q_tag.push_back("R4");
                    end
                end
                if (q_we.size() == 0) begin
                    q_we.push_back(1'b0); q_idx.push_back(0);
                    q_data.push_back(0); q_tag.push_back("R4");
                end
            end
        end else begin
            q_we.push_back(1'b0); q_idx.push_back(0); q_data.push_back(0);
            q_tag.push_back(code == 4 ? "R7" : (code == 5 ? "R8" : "R10"));
        end
        if (force_tag != "") foreach (q_tag[k]) q_tag[k] = force_tag;

        @(negedge clk);
        op = code[2:0]; dense_mode = dense; vl = vlen[IW-1:0];
        for (int k = 0; k < NE; k++) begin
            src_a[k*EW +: EW] = ea[k][EW-1:0];
            src_b[k*EW +: EW] = eb[k][EW-1:0];
        end
        scalar = es[EW-1:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = q_we.size();
        for (int k = 0; k < n; k++) begin
            check(busy == 1'b1, "R2", "busy during run", busy, 1);
            check(wr_en == q_we[k], q_tag[k], "wr_en", wr_en, q_we[k]);
            if (q_we[k]) begin
                check(int'(wr_idx) == q_idx[k], "R6", "wr_idx", wr_idx, q_idx[k]);
                check(int'(wr_data) == q_data[k], "R5", "wr_data", wr_data, q_data[k]);
            end
            check(done == (k == n - 1), "R9", "done", done, k == n - 1);
            if (poke && k == 0) start = 1'b1;
            if (poke && k == 1) start = 1'b0;
            if (k < n - 1) @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R2", "busy after done", busy, 0);
        check(done == 1'b0 && wr_en == 1'b0, "R9", "done/wr_en idle", done, 0);
        if (code == 4) foreach (ref_mask[k]) ref_mask[k] = 1'b1;
        if (code == 5) foreach (ref_mask[k])
            ref_mask[k] = (k < vlen) && (to_signed(ea[k]) > to_signed(es));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        foreach (ref_mask[k]) ref_mask[k] = 1'b1;
        for (int k = 0; k < NE; k++) begin ea[k] = 100 * k + 7; eb[k] = 3 * k + 1; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(!busy && !done && !wr_en, "R1", "idle after reset", busy, 0);
        // R1: reset mask is all ones
        run_cmd(0, 1'b0, 8, 1'b0, "R1");
        // R5: wrap-around add and subtract
        ea[0] = 16'hFFFF; eb[0] = 2; ea[1] = 0; eb[1] = 1;
        run_cmd(0, 1'b0, 2, 1'b0, "");
        run_cmd(1, 1'b0, 2, 1'b0, "");
        run_cmd(2, 1'b1, 8, 1'b0, "");
        run_cmd(3, 1'b1, 8, 1'b0, "");
        // R6: zero length in both schedules
        run_cmd(0, 1'b0, 0, 1'b0, "");
        run_cmd(0, 1'b1, 0, 1'b0, "");
        // R2: start raised mid-run is ignored
        run_cmd(1, 1'b0, 6, 1'b1, "R2");
        // R8, R4, R3: every mask pattern through the compare
        for (int m = 0; m < 256; m++) begin
            for (int k = 0; k < NE; k++) begin
                ea[k] = ((m >> k) & 1) ? 5 + k : 16'hFFFD;
                eb[k] = $urandom & 32'hFFFF;
            end
            es = (m % 3 == 0) ? 0 : 4;
            run_cmd(5, 1'b0, 8, 1'b0, "");
            run_cmd(m % 4, 1'b1, m % 9, 1'b0, "");
            if (m % 16 == 0) run_cmd(m % 4, 1'b0, 8, 1'b0, "");
        end
        // R8: bits at or above VL cleared
        for (int k = 0; k < NE; k++) ea[k] = 50;
        es = 1;
        run_cmd(5, 1'b1, 5, 1'b0, "");
        run_cmd(0, 1'b0, 8, 1'b0, "R6");
        // R10: reserved codes leave the mask as it was
        run_cmd(6, 1'b0, 8, 1'b0, "");
        run_cmd(7, 1'b1, 8, 1'b0, "");
        run_cmd(0, 1'b1, 8, 1'b0, "R10");
        // R7: set all mask bits
        run_cmd(4, 1'b0, 3, 1'b0, "");
        run_cmd(0, 1'b1, 8, 1'b0, "R7");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule